// File: doc/BRIEF.md
# Standby Stop-Mode Clock Controller

This block sequences a small microcontroller core into and out of its deepest low-power state. A one-cycle request strobe from the CPU asks for the stop state. The request is taken only when the CPU is clocked from the high-speed oscillator or from the ring oscillator. While stopped, the block turns off the high-speed oscillator, closes the CPU clock gate and freezes the port output latches. When an interrupt request that is not masked appears, the block turns the high-speed oscillator back on. It then keeps the CPU clock gated until a stabilization wait has run out, and only after that does it reopen the gate.

If an unmasked interrupt is already pending at the moment of the request, the block does not stop. It drops for one cycle into a halt-like fall-through state and then still runs the whole stabilization wait. The wait length is 2^(WAIT_BASE + WAIT_STEP*sel), where sel is a 3-bit select input taken when the wait starts. The wait advances only on cycles where the tick input is high. The tick comes from the ring oscillator or from a free-running reference. The ring oscillator keeps running in the stop state unless the keep-alive option permits a software stop and software has asked for one.

Top module: `stby_stop_ctrl`

## Requirements
- R1: A synchronous active-high reset forces state 0 (RUN). At reset both oscillator enables are 1, the CPU clock gate is open (1), the port hold is 0 and the error flag is 0.
- R2: In RUN, a stop request with clock source 0 (high-speed) or 1 (ring oscillator) and no pending unmasked interrupt moves the block to state 1 (STOP) on the next cycle. In STOP the high-speed enable is 0 and the CPU clock gate is 0.
- R3: The port hold output is 1 in every state other than RUN and 0 in RUN.
- R4: STOP is left for state 3 (WAIT) on the cycle after any interrupt line has request 1 and mask 0. A request whose mask bit is 1 leaves the block in STOP.
- R5: A stop request taken while an unmasked interrupt is already pending goes to state 2 (HALT fall-through) for exactly one cycle, then to WAIT.
- R6: WAIT lasts 2^(WAIT_BASE+WAIT_STEP*sel) cycles that have the tick high. Cycles with the tick low do not count. sel is sampled when WAIT is entered. The CPU clock gate stays 0 throughout WAIT and is 1 again in the RUN state that follows.
- R7: The high-speed oscillator enable is 1 from the first cycle of WAIT.
- R8: The ring-oscillator enable is 0 only in STOP with both the software-stoppable option and the software stop bit at 1. In all other cases it is 1.
- R9: A stop request with clock source 2 or 3 is ignored: the block stays in RUN. The same request sets an error flag that only reset clears.
- R10: Interrupt requests that arrive during WAIT do not restart or lengthen the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_i | input | 1 | Synchronous active-high reset |
| stop_req_i | input | 1 | Stop request strobe from the CPU |
| cpu_clk_src_i | input | 2 | Current CPU clock source: 0 high-speed, 1 ring oscillator, 2/3 invalid |
| irq_req_i | input | NUM_IRQ | Interrupt request flags |
| irq_mask_i | input | NUM_IRQ | Interrupt mask flags, 1 = masked |
| ro_sw_stoppable_i | input | 1 | Option bit: software may stop the ring oscillator |
| ro_stop_sw_i | input | 1 | Software ring-oscillator stop bit |
| wait_sel_i | input | SEL_W | Stabilization wait select |
| wait_tick_i | input | 1 | Count enable for the stabilization wait |
| hs_osc_en_o | output | 1 | High-speed oscillator enable |
| ro_osc_en_o | output | 1 | Ring oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| port_hold_o | output | 1 | Freeze port output latches |
| state_o | output | 2 | Current state: 0 RUN, 1 STOP, 2 HALT, 3 WAIT |
| src_err_o | output | 1 | Sticky invalid-source request flag |

## Verification
The assertions assume that the stop request and the interrupt inputs are already synchronous to the controller clock. They also assume that wait_sel_i never selects a wait wider than the counter, and that wait_tick_i is a single-cycle-qualified enable. The bench drives every input on the falling edge, so each value is stable across the next rising edge. It keeps the select within its 3-bit range, and it holds the tick low only in a bounded burst in the middle of a wait. The bench uses a short wait base so that the full range of wait lengths stays within a few hundred cycles.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_HALT = 2'd2,
        ST_WAIT = 2'd3
    } stby_state_e;

    localparam logic [1:0] SRC_HS = 2'd0;
    localparam logic [1:0] SRC_RO = 2'd1;

    typedef struct packed {
        stby_state_e state;
        logic        err;
    } stby_fsm_t;

endpackage

// File: rtl/stby_wake_detect.sv
module stby_wake_detect #(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] req_i,
    input  logic [NUM_IRQ-1:0] mask_i,
    output logic               pending_o
);

    logic [NUM_IRQ-1:0] live;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        assign live[g] = req_i[g] & ~mask_i[g];
    end

    assign pending_o = |live;

endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer #(
    parameter int SEL_W     = 3,
    parameter int WAIT_BASE = 11,
    parameter int WAIT_STEP = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tick_i,
    input  logic             active_i,
    output logic             expire_o
);

    localparam int MAX_EXP = WAIT_BASE + WAIT_STEP * ((1 << SEL_W) - 1);
    localparam int CNT_W   = MAX_EXP + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    int               shamt;

    always_comb begin
        cnt_d = cnt_q;
        shamt = WAIT_BASE + WAIT_STEP * int'(sel_i);
        if (load_i) begin
            cnt_d = CNT_W'(1) << shamt;
        end else if (active_i && tick_i && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign expire_o = active_i && tick_i && (cnt_q == CNT_W'(1));

    // R6
    cnt_live_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        active_i |-> cnt_q != '0);

    // R6
    load_pow2_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> $countones(cnt_q) == 1);

    // R6
    tick_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (active_i && !tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/stby_out_decode.sv
module stby_out_decode
    import stby_pkg::*;
(
    input  stby_state_e state_i,
    input  logic        ro_sw_stoppable_i,
    input  logic        ro_stop_sw_i,
    output logic        hs_osc_en_o,
    output logic        ro_osc_en_o,
    output logic        cpu_clk_en_o,
    output logic        port_hold_o
);

    always_comb begin
        hs_osc_en_o  = 1'b1;
        ro_osc_en_o  = 1'b1;
        cpu_clk_en_o = 1'b0;
        port_hold_o  = 1'b1;
        unique case (state_i)
            ST_RUN: begin
                cpu_clk_en_o = 1'b1;
                port_hold_o  = 1'b0;
            end
            ST_STOP: begin
                hs_osc_en_o = 1'b0;
                ro_osc_en_o = !(ro_sw_stoppable_i && ro_stop_sw_i);
            end
            ST_HALT: begin
                hs_osc_en_o = 1'b0;
            end
            ST_WAIT: begin
                hs_osc_en_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stby_stop_ctrl.sv
module stby_stop_ctrl
    import stby_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int SEL_W     = 3,
    parameter int WAIT_BASE = 11,
    parameter int WAIT_STEP = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               stop_req_i,
    input  logic [1:0]         cpu_clk_src_i,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic [NUM_IRQ-1:0] irq_mask_i,
    input  logic               ro_sw_stoppable_i,
    input  logic               ro_stop_sw_i,
    input  logic [SEL_W-1:0]   wait_sel_i,
    input  logic               wait_tick_i,
    output logic               hs_osc_en_o,
    output logic               ro_osc_en_o,
    output logic               cpu_clk_en_o,
    output logic               port_hold_o,
    output logic [1:0]         state_o,
    output logic               src_err_o
);

    stby_fsm_t fsm_d, fsm_q;
    logic      pending;
    logic      src_ok;
    logic      load_wait;
    logic      in_wait;
    logic      expire;

    stby_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .req_i     (irq_req_i),
        .mask_i    (irq_mask_i),
        .pending_o (pending)
    );

    assign src_ok = (cpu_clk_src_i == SRC_HS) || (cpu_clk_src_i == SRC_RO);

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_RUN: begin
                if (stop_req_i) begin
                    if (!src_ok)      fsm_d.err   = 1'b1;
                    else if (pending) fsm_d.state = ST_HALT;
                    else              fsm_d.state = ST_STOP;
                end
            end
            ST_STOP: if (pending) fsm_d.state = ST_WAIT;
            ST_HALT: fsm_d.state = ST_WAIT;
            ST_WAIT: if (expire) fsm_d.state = ST_RUN;
            default: fsm_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fsm_q.state <= ST_RUN;
            fsm_q.err   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign in_wait   = (fsm_q.state == ST_WAIT);
    assign load_wait = (fsm_d.state == ST_WAIT) && !in_wait;

    stby_stab_timer #(
        .SEL_W     (SEL_W),
        .WAIT_BASE (WAIT_BASE),
        .WAIT_STEP (WAIT_STEP)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load_wait),
        .sel_i    (wait_sel_i),
        .tick_i   (wait_tick_i),
        .active_i (in_wait),
        .expire_o (expire)
    );

    stby_out_decode u_dec (
        .state_i           (fsm_q.state),
        .ro_sw_stoppable_i (ro_sw_stoppable_i),
        .ro_stop_sw_i      (ro_stop_sw_i),
        .hs_osc_en_o       (hs_osc_en_o),
        .ro_osc_en_o       (ro_osc_en_o),
        .cpu_clk_en_o      (cpu_clk_en_o),
        .port_hold_o       (port_hold_o)
    );

    assign state_o   = fsm_q.state;
    assign src_err_o = fsm_q.err;

    // R2
    stop_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o == 2'd1 |-> (!hs_osc_en_o && !cpu_clk_en_o));

    // R4
    stop_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd1 && (|(irq_req_i & ~irq_mask_i))) |=> state_o == 2'd3);

    // R5
    halt_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o == 2'd2 |=> state_o == 2'd3);

    // R6
    wait_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o != 2'd0 |-> !cpu_clk_en_o);

    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        port_hold_o == (state_o != 2'd0));

    // R7
    wait_hs_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o == 2'd3 |-> hs_osc_en_o);

    // R8
    ro_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(ro_sw_stoppable_i && ro_stop_sw_i) |-> ro_osc_en_o);

    // R9
    bad_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd0 && stop_req_i && cpu_clk_src_i[1]) |=> (state_o == 2'd0 && src_err_o));

    // R9
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        src_err_o |=> src_err_o);

    // R10
    wait_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd0));

endmodule

// File: tb/tb_stby_stop_ctrl.sv
module tb_stby_stop_ctrl;

    localparam int N = 8;
    localparam logic [1:0] S_RUN = 2'd0, S_STOP = 2'd1, S_HALT = 2'd2, S_WAIT = 2'd3;

    logic         clk = 1'b0;
    logic         rst;
    logic         stop_req;
    logic [1:0]   src;
    logic [N-1:0] req, mask;
    logic         opt, sw;
    logic [2:0]   sel;
    logic         tick;
    logic         hs, ro, gate, hold, err;
    logic [1:0]   st;

    always #10 clk = ~clk;

    stby_stop_ctrl #(.NUM_IRQ(N), .SEL_W(3), .WAIT_BASE(2), .WAIT_STEP(1)) dut (
        .clk_i             (clk),
        .rst_i             (rst),
        .stop_req_i        (stop_req),
        .cpu_clk_src_i     (src),
        .irq_req_i         (req),
        .irq_mask_i        (mask),
        .ro_sw_stoppable_i (opt),
        .ro_stop_sw_i      (sw),
        .wait_sel_i        (sel),
        .wait_tick_i       (tick),
        .hs_osc_en_o       (hs),
        .ro_osc_en_o       (ro),
        .cpu_clk_en_o      (gate),
        .port_hold_o       (hold),
        .state_o           (st),
        .src_err_o         (err)
    );

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    logic  err_exp = 1'b0;
    int    q_cyc[$];
    logic [6:0] q_val[$];
    string q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int d, input logic [1:0] s, input string tag);
        logic [6:0] v;
        v = {err_exp, s != S_RUN, s == S_RUN, !(s == S_STOP && opt && sw),
             !(s == S_STOP || s == S_HALT), s};
        q_cyc.push_back(cyc + d);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    always @(posedge clk) begin
        #5;
        for (int i = q_cyc.size() - 1; i >= 0; i--) begin
            if (q_cyc[i] == cyc) begin
                logic [6:0] act;
                act = {err, hold, gate, ro, hs, st};
                n_chk++;
                if (act !== q_val[i]) begin
                    n_fail++;
                    $display("FAIL %s cyc=%0d {err,hold,gate,ro,hs,st} actual=%b expected=%b",
                             q_tag[i], cyc, act, q_val[i]);
                end
                q_cyc.delete(i);
                q_val.delete(i);
                q_tag.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; stop_req = 1'b0; src = 2'd0; req = '0; mask = '0;
        opt = 1'b0; sw = 1'b1; sel = 3'd0; tick = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        push(1, S_RUN, "R1 reset state");
        repeat (2) @(negedge clk);

        // R2 R3 R4 R6 R7, ring osc kept (opt=0)
        stop_req = 1'b1;
        push(1, S_STOP, "R2/R3 stop entry");
        @(negedge clk); stop_req = 1'b0;
        @(negedge clk);
        req = 8'h04; mask = 8'h04;
        push(1, S_STOP, "R4 masked ignored");
        push(2, S_STOP, "R8 ro kept, option off");
        repeat (2) @(negedge clk);
        mask = 8'h00;
        push(1, S_WAIT, "R4/R7 wake to wait");
        push(4, S_WAIT, "R6 sel0 last wait cycle");
        push(5, S_RUN,  "R6 sel0 back to run");
        repeat (6) @(negedge clk);
        req = '0;
        @(negedge clk);

        // R5 fall-through, R10 new irq in wait, R6 sel sampled at entry
        src = 2'd1; sel = 3'd1; req = 8'h20;
        stop_req = 1'b1;
        push(1, S_HALT, "R5 halt fall-through");
        push(2, S_WAIT, "R5 halt to wait");
        push(9, S_WAIT, "R10 wait not restarted");
        push(10, S_RUN, "R6 sel1 back to run");
        @(negedge clk); stop_req = 1'b0;
        repeat (3) @(negedge clk);
        req = 8'h22; sel = 3'd0;
        repeat (6) @(negedge clk);
        req = '0;
        @(negedge clk);

        // R8 ring osc stopped, R6 tick gating
        opt = 1'b1; sw = 1'b1; src = 2'd0; sel = 3'd0;
        stop_req = 1'b1;
        push(1, S_STOP, "R8 ro stopped in stop");
        @(negedge clk); stop_req = 1'b0;
        @(negedge clk);
        req = 8'h01; tick = 1'b0;
        push(1, S_WAIT, "R7 wait hs on, ro on");
        push(5, S_WAIT, "R6 tick low holds wait");
        push(8, S_WAIT, "R6 tick gated last cycle");
        push(9, S_RUN,  "R6 tick gated exit");
        repeat (5) @(negedge clk);
        tick = 1'b1;
        repeat (5) @(negedge clk);
        req = '0; opt = 1'b0;
        @(negedge clk);

        // R9 invalid source
        src = 2'd2; stop_req = 1'b1; err_exp = 1'b1;
        push(1, S_RUN, "R9 invalid source ignored");
        @(negedge clk); src = 2'd3;
        push(1, S_RUN, "R9 invalid source 3 ignored");
        @(negedge clk); stop_req = 1'b0; src = 2'd0;
        @(negedge clk);
        stop_req = 1'b1;
        push(1, S_STOP, "R9 error sticky in stop");
        @(negedge clk); stop_req = 1'b0;
        @(negedge clk);

        // R1 reset from stop clears everything
        rst = 1'b1; err_exp = 1'b0;
        push(1, S_RUN, "R1 reset from stop");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        push(1, S_RUN, "R1 after reset release");

        // R6 larger select
        @(negedge clk);
        sel = 3'd2; stop_req = 1'b1;
        push(1, S_STOP, "R2 stop again");
        @(negedge clk); stop_req = 1'b0;
        @(negedge clk);
        req = 8'h80;
        push(16, S_WAIT, "R6 sel2 last wait cycle");
        push(17, S_RUN,  "R6 sel2 back to run");
        repeat (20) @(negedge clk);
        req = '0;
        repeat (3) @(negedge clk);

        if (q_cyc.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard (all requirements) actual=%0d pending expected=0", q_cyc.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule